// File: doc/BRIEF.md
# Palette DAC Snoop Claim Logic

This block is the I/O target decoder of a graphics device that sits on a PCI-style bus next to a bridge that decodes subtractively. It watches each address phase for I/O reads and I/O writes to the four palette DAC ports. These are the pixel mask, the read index, the write index and the colour data. It then decides whether to take the cycle with a DEVSEL/TRDY handshake or to stay silent while it copies the write data.

A configuration bit, `claim_mode`, selects the policy. When it is set, reads and writes to the ports are both claimed. When it is clear, reads are still claimed, but writes are only snooped. The block latches the data the first time the master marks it valid and never drives DEVSEL or TRDY for that write, so the bridge can take the write by subtractive decode and pass it to a graphics card on the expansion bus that keeps its own copy of the palette.

Writes to the data port load a palette RAM of `ENTRIES` colours with three components each, using a component counter and an index that auto-increments. Each such write also appears on a strobe interface. Data-port reads walk the RAM in the same way through a separate read index.

Top module: `pal_snoop_claim`

## Requirements
- R1: After reset, `devsel`, `trdy` and `pal_we` are low, `rdata` is zero, `claim_mode` is 1, the indices and counters are 0, the mask is 0 and the palette RAM holds zeros.
- R2: An address phase (`addr_valid`=1 in idle) is a hit only when all of the following are true. The command is I/O read (4'b0010) or I/O write (4'b0011). `bus_addr` is in 16'h03C6..16'h03C9. The byte enable of lane `bus_addr[1:0]` is set. Any other address phase, including memory commands, produces no `devsel`, no `trdy`, no `pal_we` and no register change.
- R3: A claimed cycle drives `devsel` and `trdy` high from the cycle after the address phase until the cycle in which `data_valid` is 1, and it completes in that cycle.
- R4: With `claim_mode`=1, a write hit is claimed as in R3 and updates the addressed register in its completion cycle.
- R5: With `claim_mode`=0, a write hit never raises `devsel` or `trdy`. Its data is still captured in the first cycle after the address phase in which `data_valid` is 1.
- R6: A read hit is claimed as in R3 whatever the value of `claim_mode`. While `trdy` is high, `rdata` carries the addressed byte on lane `bus_addr[1:0]` and zeros on the other lanes. Outside a read completion, `rdata` is zero.
- R7: `cfg_we`=1 loads `cfg_din` into `claim_mode` at the clock edge. Each cycle keeps the mode that was in force at its own address phase.
- R8: Each data-port write (port 16'h03C9) stores the byte in component `pal_comp` of entry `pal_idx`. It then advances the component counter 0→1→2→0. After component 2, the write index steps by one and wraps from ENTRIES-1 to 0. A write to port 16'h03C8 loads the write index and clears that counter. Both modes behave the same way.
- R9: A data-port read returns component `c` of entry `i`, where `c` and `i` are the current read counter and read index. It then advances them in the same way as R8. A write to port 16'h03C7 loads the read index and clears the read counter.
- R10: Port 16'h03C6 reads and writes an 8-bit mask. A read of 16'h03C7 returns the read index, and a read of 16'h03C8 returns the write index.
- R11: In the completion cycle of every data-port write, claimed or snooped, `pal_we` pulses with `pal_idx`, `pal_comp` and `pal_data`. `pal_data` is the write byte taken from lane `bus_addr[1:0]`.
- R12: An `addr_valid` that arrives while a cycle is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the claim-mode bit |
| cfg_din | input | 1 | New claim-mode value |
| addr_valid | input | 1 | Address phase present this cycle |
| bus_addr | input | AW | Byte address of the access |
| bus_cmd | input | 4 | Bus command |
| bus_be | input | DW/8 | Byte enables, active high |
| data_valid | input | 1 | Master data valid (write data, or ready for read data) |
| wdata | input | DW | Write data |
| devsel | output | 1 | Target claims the cycle |
| trdy | output | 1 | Target ready |
| rdata | output | DW | Read data, valid while `trdy` is high on a read |
| pal_we | output | 1 | Palette component write strobe |
| pal_idx | output | $clog2(ENTRIES) | Entry being written |
| pal_comp | output | 2 | Component being written (0, 1, 2) |
| pal_data | output | 8 | Component value |

## Verification
On every cycle, assertions check the following. A read hit is claimed on the next cycle in both modes. A write hit in snoop mode stays silent on the next cycle. A miss leaves the target idle. A pending claim holds until data is valid. The write and read indices step at the third component. Only the bench's scenarios can show the rest. These are lane selection of write and read data, the full palette store-and-read-back path in both modes, the effect of a mode change during a pending cycle, ignored address phases while busy, index wrap, and the absence of register side effects from misses. All of these are compared every clock against a behavioural model.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam logic [3:0]  CMD_IO_RD = 4'b0010;
  localparam logic [3:0]  CMD_IO_WR = 4'b0011;
  localparam logic [15:0] PORT_BASE = 16'h03C6;
  localparam int          PORT_CNT  = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CLAIM_RD = 2'd1,
    ST_CLAIM_WR = 2'd2,
    ST_SNOOP    = 2'd3
  } tgt_state_e;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_WIDX = 2'd2,
    SEL_DATA = 2'd3
  } port_sel_e;

  // next RGB component, wrapping after the third
  function automatic logic [1:0] next_comp(input logic [1:0] c);
    return (c == 2'd2) ? 2'd0 : c + 2'd1;
  endfunction
endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int BEW = DW / 8,
  localparam int LW = $clog2(BEW)
) (
  input  logic [AW-1:0]  addr,
  input  logic [3:0]     cmd,
  input  logic [BEW-1:0] be,
  output logic           hit,
  output logic           is_read,
  output port_sel_e      sel,
  output logic [LW-1:0]  lane
);
  localparam logic [AW-1:0] LO = AW'(PORT_BASE);
  localparam logic [AW-1:0] HI = AW'(PORT_BASE + PORT_CNT - 1);

  function automatic logic in_window(input logic [AW-1:0] a);
    return (a >= LO) && (a <= HI);
  endfunction

  function automatic logic io_cmd(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR);
  endfunction

  logic [1:0] port_off;

  always_comb begin
    lane     = addr[LW-1:0];
    port_off = 2'(addr[1:0] - PORT_BASE[1:0]);
    sel      = port_sel_e'(port_off);
    is_read  = (cmd == CMD_IO_RD);
    hit      = in_window(addr) && io_cmd(cmd) && be[lane];
  end
endmodule

// File: rtl/pal_target_fsm.sv
module pal_target_fsm
  import pal_pkg::*;
#(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_valid,
  input  logic          hit,
  input  logic          is_read,
  input  port_sel_e     sel_in,
  input  logic [LW-1:0] lane_in,
  input  logic          claim_mode,
  input  logic          data_valid,
  output logic          devsel,
  output logic          trdy,
  output logic          rd_active,
  output logic          commit_wr,
  output logic          commit_rd,
  output port_sel_e     sel_q,
  output logic [LW-1:0] lane_q
);
  tgt_state_e state_q;
  logic       addr_hit;
  logic       pending;

  assign addr_hit = addr_valid && hit;
  assign pending  = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= SEL_MASK;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (addr_hit) begin
            sel_q  <= sel_in;
            lane_q <= lane_in;
            if (is_read)         state_q <= ST_CLAIM_RD;
            else if (claim_mode) state_q <= ST_CLAIM_WR;
            else                 state_q <= ST_SNOOP;
          end
        end
        default: if (data_valid) state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    devsel    = (state_q == ST_CLAIM_RD) || (state_q == ST_CLAIM_WR);
    trdy      = devsel;
    rd_active = (state_q == ST_CLAIM_RD);
    commit_rd = data_valid && (state_q == ST_CLAIM_RD);
    commit_wr = data_valid && ((state_q == ST_CLAIM_WR) || (state_q == ST_SNOOP));
  end

  // R6
  claim_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && addr_hit && is_read) |=> (devsel && trdy));

  // R4
  claim_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && addr_hit && !is_read && claim_mode) |=> (devsel && trdy));

  // R5
  snoop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && addr_hit && !is_read && !claim_mode) |=> (!devsel && !trdy));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !addr_hit) |=> !devsel);

  // R3
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel && !data_valid) |=> (devsel && $stable(sel_q)));
endmodule

// File: rtl/pal_regs.sv
module pal_regs
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int CW = 8,
  parameter int DW = 32,
  localparam int IW = $clog2(ENTRIES),
  localparam int LW = $clog2(DW / 8),
  localparam int RAMD = ENTRIES * 3,
  localparam int RAW = $clog2(RAMD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_wr,
  input  logic          commit_rd,
  input  port_sel_e     sel,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pal_we,
  output logic [IW-1:0] pal_idx,
  output logic [1:0]    pal_comp,
  output logic [7:0]    pal_data
);
  logic [7:0]    mask_q;
  logic [IW-1:0] widx_q, ridx_q;
  logic [1:0]    wcomp_q, rcomp_q;
  logic [CW-1:0] ram_q [RAMD];
  logic [7:0]    wbyte, rbyte;

  function automatic logic [7:0] lane_byte(input logic [DW-1:0] d, input logic [LW-1:0] l);
    return d[{l, 3'b000} +: 8];
  endfunction

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] i, input logic [1:0] c);
    if (c != 2'd2) return i;
    return (int'(i) == ENTRIES - 1) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [RAW-1:0] ram_addr(input logic [IW-1:0] i, input logic [1:0] c);
    return RAW'(int'(i) * 3 + int'(c));
  endfunction

  assign wbyte = lane_byte(wdata, lane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      widx_q  <= '0;
      ridx_q  <= '0;
      wcomp_q <= '0;
      rcomp_q <= '0;
    end else if (commit_wr) begin
      unique case (sel)
        SEL_MASK: mask_q <= wbyte;
        SEL_RIDX: begin ridx_q <= wbyte[IW-1:0]; rcomp_q <= '0; end
        SEL_WIDX: begin widx_q <= wbyte[IW-1:0]; wcomp_q <= '0; end
        SEL_DATA: begin
          wcomp_q <= next_comp(wcomp_q);
          widx_q  <= step_idx(widx_q, wcomp_q);
        end
        default: ;
      endcase
    end else if (commit_rd && sel == SEL_DATA) begin
      rcomp_q <= next_comp(rcomp_q);
      ridx_q  <= step_idx(ridx_q, rcomp_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < RAMD; k++) ram_q[k] <= '0;
    end else if (pal_we) begin
      ram_q[ram_addr(widx_q, wcomp_q)] <= wbyte[CW-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rbyte = mask_q;
      SEL_RIDX: rbyte = 8'(ridx_q);
      SEL_WIDX: rbyte = 8'(widx_q);
      default:  rbyte = 8'(ram_q[ram_addr(ridx_q, rcomp_q)]);
    endcase
    rdata    = DW'(rbyte) << {lane, 3'b000};
    pal_we   = commit_wr && (sel == SEL_DATA);
    pal_idx  = widx_q;
    pal_comp = wcomp_q;
    pal_data = wbyte;
  end

  // R8
  index_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_we && wcomp_q == 2'd2) |=> (wcomp_q == 2'd0 && (widx_q == '0 || widx_q == $past(widx_q) + 1'b1)));

  // R9
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_rd && sel == SEL_DATA && rcomp_q == 2'd2) |=> (rcomp_q == 2'd0 && (ridx_q == '0 || ridx_q == $past(ridx_q) + 1'b1)));
endmodule

// File: rtl/pal_snoop_claim.sv
module pal_snoop_claim
  import pal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int ENTRIES = 256,
  parameter int CW = 8,
  localparam int BEW = DW / 8,
  localparam int LW = $clog2(BEW),
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_din,
  input  logic           addr_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [3:0]     bus_cmd,
  input  logic [BEW-1:0] bus_be,
  input  logic           data_valid,
  input  logic [DW-1:0]  wdata,
  output logic           devsel,
  output logic           trdy,
  output logic [DW-1:0]  rdata,
  output logic           pal_we,
  output logic [IW-1:0]  pal_idx,
  output logic [1:0]     pal_comp,
  output logic [7:0]     pal_data
);
  logic          claim_mode;
  logic          dec_hit, dec_read;
  port_sel_e     dec_sel, cur_sel;
  logic [LW-1:0] dec_lane, cur_lane;
  logic          rd_active, commit_wr, commit_rd;
  logic [DW-1:0] reg_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n)      claim_mode <= 1'b1;
    else if (cfg_we) claim_mode <= cfg_din;
  end

  pal_decode #(.AW(AW), .DW(DW)) u_dec (
    .addr(bus_addr), .cmd(bus_cmd), .be(bus_be),
    .hit(dec_hit), .is_read(dec_read), .sel(dec_sel), .lane(dec_lane)
  );

  pal_target_fsm #(.LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
    .hit(dec_hit), .is_read(dec_read), .sel_in(dec_sel), .lane_in(dec_lane),
    .claim_mode(claim_mode), .data_valid(data_valid),
    .devsel(devsel), .trdy(trdy), .rd_active(rd_active),
    .commit_wr(commit_wr), .commit_rd(commit_rd),
    .sel_q(cur_sel), .lane_q(cur_lane)
  );

  pal_regs #(.ENTRIES(ENTRIES), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_wr(commit_wr), .commit_rd(commit_rd),
    .sel(cur_sel), .lane(cur_lane), .wdata(wdata), .rdata(reg_rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_comp(pal_comp), .pal_data(pal_data)
  );

  assign rdata = rd_active ? reg_rdata : '0;
endmodule

// File: tb/pal_snoop_claim_test.sv
`timescale 1ns/1ps
module pal_snoop_claim_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_din = 1'b0;
  logic        addr_valid = 1'b0, data_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [3:0]  bus_cmd = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] wdata = '0;
  logic        devsel, trdy, pal_we;
  logic [31:0] rdata;
  logic [7:0]  pal_idx, pal_data;
  logic [1:0]  pal_comp;

  pal_snoop_claim uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .addr_valid(addr_valid), .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_be(bus_be),
    .data_valid(data_valid), .wdata(wdata), .devsel(devsel), .trdy(trdy), .rdata(rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_comp(pal_comp), .pal_data(pal_data)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_st, m_sel, m_lane, m_mode, m_mask, m_widx, m_wc, m_ridx, m_rc;
  int m_ram [0:767];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_sel = 0; m_lane = 0; m_mode = 1; m_mask = 0;
    m_widx = 0; m_wc = 0; m_ridx = 0; m_rc = 0;
    foreach (m_ram[k]) m_ram[k] = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      model_reset();
      // R1 outputs quiet in reset
      chk("devsel", 32'(devsel), 0); chk("trdy", 32'(trdy), 0);
      chk("pal_we", 32'(pal_we), 0); chk("rdata", rdata, 0);
    end else begin
      automatic bit claimed = (m_st == 1 || m_st == 2);
      automatic bit wr_done = data_valid && (m_st == 2 || m_st == 3);
      automatic bit rd_done = data_valid && m_st == 1;
      automatic int wb = (wdata >> (8 * m_lane)) & 8'hFF;
      automatic int rb = 0;
      automatic logic [31:0] exp_rd = 0;
      if (m_sel == 0) rb = m_mask;
      else if (m_sel == 1) rb = m_ridx;
      else if (m_sel == 2) rb = m_widx;
      else rb = m_ram[m_ridx * 3 + m_rc];
      if (m_st == 1) exp_rd = 32'(rb) << (8 * m_lane);
      chk("devsel", 32'(devsel), 32'(claimed));
      chk("trdy", 32'(trdy), 32'(claimed));
      chk("rdata", rdata, exp_rd);
      chk("pal_we", 32'(pal_we), 32'(wr_done && m_sel == 3));
      if (wr_done && m_sel == 3) begin
        chk("pal_idx", 32'(pal_idx), 32'(m_widx));
        chk("pal_comp", 32'(pal_comp), 32'(m_wc));
        chk("pal_data", 32'(pal_data), 32'(wb));
      end
      // state update for the coming edge
      if (m_st == 0) begin
        if (addr_valid && (bus_cmd == 4'h2 || bus_cmd == 4'h3) &&
            bus_addr >= 16'h3C6 && bus_addr <= 16'h3C9 && bus_be[bus_addr[1:0]]) begin
          m_sel = int'(bus_addr) - 'h3C6;
          m_lane = int'(bus_addr[1:0]);
          m_st = (bus_cmd == 4'h2) ? 1 : (m_mode != 0 ? 2 : 3);
        end
      end else if (data_valid) begin
        if (wr_done) begin
          case (m_sel)
            0: m_mask = wb;
            1: begin m_ridx = wb; m_rc = 0; end
            2: begin m_widx = wb; m_wc = 0; end
            default: begin
              m_ram[m_widx * 3 + m_wc] = wb;
              m_wc++;
              if (m_wc == 3) begin m_wc = 0; m_widx = (m_widx + 1) % 256; end
            end
          endcase
        end else if (rd_done && m_sel == 3) begin
          m_rc++;
          if (m_rc == 3) begin m_rc = 0; m_ridx = (m_ridx + 1) % 256; end
        end
        m_st = 0;
      end
      if (cfg_we) m_mode = cfg_din;
    end
  end

  function automatic logic [31:0] place(input logic [15:0] a, input logic [7:0] b);
    logic [31:0] w = 32'h5AC3_96E1;
    w[8*a[1:0] +: 8] = b;
    return w;
  endfunction

  task automatic access(input logic [15:0] a, input logic [3:0] cmd, input logic [3:0] be,
                        input logic [7:0] b, input int waits);
    @(posedge clk); #1;
    addr_valid = 1; bus_addr = a; bus_cmd = cmd; bus_be = be; wdata = place(a, b);
    @(posedge clk); #1;
    addr_valid = 0;
    for (int w = 0; w < waits; w++) begin @(posedge clk); #1; end
    data_valid = 1;
    @(posedge clk); #1;
    data_valid = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] b, input int waits);
    access(a, 4'h3, 4'b0001 << a[1:0], b, waits);
  endtask

  task automatic rd(input logic [15:0] a, input int waits);
    access(a, 4'h2, 4'b0001 << a[1:0], 8'h00, waits);
  endtask

  task automatic set_mode(input logic v);
    @(posedge clk); #1; cfg_we = 1; cfg_din = v;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    automatic logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: after reset the mode claims writes
    cur_req = "R1"; wr(16'h3C8, 8'h10, 0);
    cur_req = "R4"; for (int k = 0; k < 6; k++) wr(16'h3C9, 8'(8'h40 + k), k % 2);
    cur_req = "R10"; wr(16'h3C6, 8'hC3, 0); rd(16'h3C6, 0); rd(16'h3C8, 1); rd(16'h3C7, 0);
    cur_req = "R9"; wr(16'h3C7, 8'h10, 0); for (int k = 0; k < 6; k++) rd(16'h3C9, k % 3);
    cur_req = "R3"; rd(16'h3C6, 4);
    // R7 then R5: snoop mode, writes silent but captured
    cur_req = "R7"; set_mode(1'b0);
    cur_req = "R5"; wr(16'h3C8, 8'h20, 0);
    cur_req = "R11"; for (int k = 0; k < 6; k++) wr(16'h3C9, 8'(8'h90 + k), k % 3);
    cur_req = "R6"; wr(16'h3C7, 8'h20, 2); for (int k = 0; k < 6; k++) rd(16'h3C9, 0);
    rd(16'h3C8, 0);
    // R2: misses leave everything unchanged
    cur_req = "R2";
    access(16'h3C5, 4'h3, 4'hF, 8'h77, 0);
    access(16'h3CA, 4'h2, 4'hF, 8'h77, 0);
    access(16'h3C9, 4'h7, 4'hF, 8'h77, 0);
    access(16'h3C8, 4'h6, 4'hF, 8'h77, 0);
    access(16'h3C8, 4'h3, 4'b1110, 8'h77, 0);
    access(16'h3C9, 4'h2, 4'b1101, 8'h00, 0);
    rd(16'h3C8, 0); rd(16'h3C7, 0);
    // R12: a second address phase during a pending cycle is ignored
    cur_req = "R12";
    @(posedge clk); #1; addr_valid = 1; bus_addr = 16'h3C6; bus_cmd = 4'h3; bus_be = 4'h4; wdata = place(16'h3C6, 8'h11);
    @(posedge clk); #1; bus_addr = 16'h3C8; bus_be = 4'h1; wdata = place(16'h3C6, 8'h22);
    @(posedge clk); #1; addr_valid = 0; data_valid = 1;
    @(posedge clk); #1; data_valid = 0;
    rd(16'h3C6, 0); rd(16'h3C8, 0);
    // R8: write index wraps after the last entry, in snoop mode
    cur_req = "R8"; wr(16'h3C8, 8'hFF, 0); for (int k = 0; k < 4; k++) wr(16'h3C9, 8'(k), 0);
    rd(16'h3C8, 0);
    // R7: mode change while a snooped write waits keeps it unclaimed
    cur_req = "R7";
    @(posedge clk); #1; addr_valid = 1; bus_addr = 16'h3C9; bus_cmd = 4'h3; bus_be = 4'h2; wdata = place(16'h3C9, 8'hEE);
    @(posedge clk); #1; addr_valid = 0; cfg_we = 1; cfg_din = 1;
    @(posedge clk); #1; cfg_we = 0; data_valid = 1;
    @(posedge clk); #1; data_valid = 0;
    wr(16'h3C9, 8'hDD, 0);
    // R2: pseudo-random mix of hits and misses in both modes
    cur_req = "R2";
    for (int k = 0; k < 400; k++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      if (seed[31:28] == 4'h0) set_mode(seed[27]);
      access(16'h3C4 + 16'(seed[2:0]),
             seed[3] ? (seed[4] ? 4'h3 : 4'h2) : (seed[4] ? 4'h7 : 4'h6),
             seed[5] ? 4'hF : seed[9:6], seed[17:10], int'(seed[19:18]) % 3);
    end
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule